// File: doc/BRIEF.md
# Set-Associative Cache Tag Directory

This block models the bookkeeping side of a set-associative cache. It keeps a tag, a valid bit and a recency stamp for every line, and no data bytes. A requester presents one typed access per cycle: an operation code and a 64-bit byte address. For each load, store or modify, the block looks up the indexed set, decides hit or miss, fills or replaces a line, and returns a one-cycle response with hit, miss and eviction flags. Running totals of hits, misses and evictions are held in saturating counters that are read straight off the ports.

Replacement is least-recently-used. A free-running access clock advances once per lookup, and any line that hits or is written takes the new clock value as its stamp. A full set gives up its line with the oldest stamp. Instruction fetches are accepted on the handshake and then dropped. The number of sets, the block size and the number of ways are compile-time parameters. This makes the block useful for sizing studies and as a hit/miss oracle next to a real cache.

Top module: `cache_tag_dir`

## Requirements
- R1: The address is split into a byte offset in bits [OFFSET_BITS-1:0], a set index in the next SET_BITS bits, and a tag made of all remaining upper bits up to bit 63. Addresses that differ only in the offset refer to the same line.
- R2: A lookup hits only when a valid line in the indexed set holds a tag equal to the address tag. Otherwise it misses, and each response raises exactly one of hit and miss.
- R3: On a miss where the set still has an invalid line, the lowest-numbered invalid way is written with the new tag and marked valid. No eviction is flagged or counted.
- R4: On a miss where every way of the set is valid, the way with the smallest stamp is replaced. The lowest-numbered way wins a tie. The response flags an eviction and the eviction counter advances.
- R5: Each lookup advances the access clock by one. The line that hits or is written takes the new clock value as its stamp, so a hit refreshes a line's recency.
- R6: Operation codes are 2'b00 instruction fetch, 2'b01 load, 2'b10 store and 2'b11 modify. Load and store each perform exactly one lookup and behave identically.
- R7: A modify performs one lookup and advances the clock once, then records one further hit regardless of the outcome. The response raises the extra-hit flag, and the hit counter rises by one more than the lookup alone would give.
- R8: An instruction fetch produces no response, changes no line, and leaves every counter and the access clock unchanged.
- R9: While reset is high, every line becomes invalid and all stamps, the access clock and all three counters become zero. No response is raised.
- R10: The hit, miss and eviction counters are CNT_W bits wide (32 by default). Each one holds at its all-ones value instead of wrapping. The access clock is STAMP_W bits wide and wraps.
- R11: acc_ready is high whenever reset is low. An access accepted at a clock edge updates the counters at that edge and raises rsp_valid for exactly the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access request present |
| acc_ready | output | 1 | Access can be taken (held high out of reset) |
| acc_op | input | 2 | Operation code: fetch, load, store or modify |
| acc_addr | input | 64 | Byte address of the access |
| rsp_valid | output | 1 | Response for the previous cycle's lookup |
| rsp_hit | output | 1 | Lookup found the line |
| rsp_miss | output | 1 | Lookup did not find the line |
| rsp_evict | output | 1 | A valid line was replaced |
| rsp_extra_hit | output | 1 | Modify recorded its additional hit |
| hit_count | output | CNT_W | Saturating total of hits |
| miss_count | output | CNT_W | Saturating total of misses |
| evict_count | output | CNT_W | Saturating total of evictions |

## Verification
The bench builds the directory with four sets, four-byte blocks and two ways, and narrows the counters to 8 bits. With five tags rotating through four sets, fills, LRU replacements, refreshing hits and tie-free victim choices all occur within a few hundred accesses. The narrow counters reach their ceiling of 255 within the same run, so saturation is exercised rather than argued. A small arithmetic model in the bench tracks valid bits, tags and stamps for all eight lines. It predicts every flag and counter value for directed sequences and for a long mixed-operation sweep. A few addresses carry bit 63 set to prove that the top tag bit takes part in matching.

// File: rtl/cache_dir_pkg.sv
package cache_dir_pkg;

    typedef enum logic [1:0] {
        OP_FETCH  = 2'b00,
        OP_LOAD   = 2'b01,
        OP_STORE  = 2'b10,
        OP_MODIFY = 2'b11
    } acc_op_e;

    typedef struct packed {
        logic valid;
        logic hit;
        logic miss;
        logic evict;
        logic extra_hit;
    } acc_rsp_t;

    // True for operations that consult the directory.
    function automatic logic is_lookup(acc_op_e op);
        return op != OP_FETCH;
    endfunction

    // Hits credited for one access: lookup hit plus the modify bonus.
    function automatic logic [1:0] hit_bump(logic lookup_hit, logic bonus);
        return {1'b0, lookup_hit} + {1'b0, bonus};
    endfunction

endpackage

// File: rtl/cd_addr_split.sv
module cd_addr_split #(
    parameter int ADDR_W      = 64,
    parameter int SET_BITS    = 2,
    parameter int OFFSET_BITS = 4,
    localparam int TAG_W      = ADDR_W - SET_BITS - OFFSET_BITS
) (
    input  logic [ADDR_W-1:0]   addr,
    output logic [SET_BITS-1:0] set_idx,
    output logic [TAG_W-1:0]    tag
);
    // Offset bits select a byte inside the block; the directory never needs them.
    logic unused_offset;
    assign unused_offset = ^addr[OFFSET_BITS-1:0];

    assign set_idx = addr[OFFSET_BITS +: SET_BITS];
    assign tag     = addr[ADDR_W-1 -: TAG_W];
endmodule

// File: rtl/cd_way_select.sv
module cd_way_select #(
    parameter int WAYS    = 4,
    parameter int TAG_W   = 58,
    parameter int STAMP_W = 32,
    localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic [WAYS-1:0]              row_valid,
    input  logic [WAYS-1:0][TAG_W-1:0]   row_tag,
    input  logic [WAYS-1:0][STAMP_W-1:0] row_stamp,
    input  logic [TAG_W-1:0]             req_tag,
    output logic                         hit,
    output logic [WAY_W-1:0]             hit_way,
    output logic                         free_any,
    output logic [WAY_W-1:0]             free_way,
    output logic [WAY_W-1:0]             lru_way
);
    logic [WAYS-1:0] match;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = row_valid[w] && (row_tag[w] == req_tag);
    end

    assign hit      = |match;
    assign free_any = ~&row_valid;

    // Scanning downward lets the lowest index win.
    always_comb begin
        hit_way  = '0;
        free_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w])      hit_way  = WAY_W'(w);
            if (!row_valid[w]) free_way = WAY_W'(w);
        end
    end

    // Strict compare keeps the earlier way on equal stamps.
    logic [STAMP_W-1:0] best_stamp;
    always_comb begin
        best_stamp = row_stamp[0];
        lru_way    = '0;
        for (int w = 1; w < WAYS; w++) begin
            if (row_stamp[w] < best_stamp) begin
                best_stamp = row_stamp[w];
                lru_way    = WAY_W'(w);
            end
        end
    end
endmodule

// File: rtl/cd_tally.sv
module cd_tally #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       bump,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W:0] sum;

    assign sum = {1'b0, count} + (CNT_W + 1)'(bump);

    always_ff @(posedge clk) begin
        if (rst)             count <= '0;
        else if (sum[CNT_W]) count <= '1;
        else                 count <= sum[CNT_W-1:0];
    end
endmodule

// File: rtl/cache_tag_dir.sv
module cache_tag_dir
    import cache_dir_pkg::*;
#(
    parameter int SET_BITS    = 2,
    parameter int OFFSET_BITS = 4,
    parameter int WAYS        = 4,
    parameter int CNT_W       = 32,
    parameter int STAMP_W     = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             acc_valid,
    output logic             acc_ready,
    input  logic [1:0]       acc_op,
    input  logic [63:0]      acc_addr,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic             rsp_miss,
    output logic             rsp_evict,
    output logic             rsp_extra_hit,
    output logic [CNT_W-1:0] hit_count,
    output logic [CNT_W-1:0] miss_count,
    output logic [CNT_W-1:0] evict_count
);
    localparam int ADDR_W   = 64;
    localparam int NUM_SETS = 1 << SET_BITS;
    localparam int TAG_W    = ADDR_W - SET_BITS - OFFSET_BITS;
    localparam int WAY_W    = (WAYS > 1) ? $clog2(WAYS) : 1;

    // Directory state, one packed row per set.
    logic [WAYS-1:0]              vld_q [NUM_SETS];
    logic [WAYS-1:0][TAG_W-1:0]   tag_q [NUM_SETS];
    logic [WAYS-1:0][STAMP_W-1:0] stp_q [NUM_SETS];
    logic [STAMP_W-1:0]           stamp_q;
    acc_rsp_t                     rsp_q;

    acc_op_e             op;
    logic                lookup;
    logic [SET_BITS-1:0] set_idx;
    logic [TAG_W-1:0]    req_tag;
    logic                hit, free_any;
    logic [WAY_W-1:0]    hit_way, free_way, lru_way, tgt_way;
    logic [STAMP_W-1:0]  stamp_nxt;

    assign acc_ready = !rst;
    assign op        = acc_op_e'(acc_op);
    assign lookup    = acc_valid && acc_ready && is_lookup(op);
    assign stamp_nxt = stamp_q + STAMP_W'(1);

    cd_addr_split #(
        .ADDR_W(ADDR_W), .SET_BITS(SET_BITS), .OFFSET_BITS(OFFSET_BITS)
    ) u_split (
        .addr(acc_addr), .set_idx(set_idx), .tag(req_tag)
    );

    cd_way_select #(
        .WAYS(WAYS), .TAG_W(TAG_W), .STAMP_W(STAMP_W)
    ) u_sel (
        .row_valid(vld_q[set_idx]),
        .row_tag  (tag_q[set_idx]),
        .row_stamp(stp_q[set_idx]),
        .req_tag  (req_tag),
        .hit      (hit),
        .hit_way  (hit_way),
        .free_any (free_any),
        .free_way (free_way),
        .lru_way  (lru_way)
    );

    // Hit refreshes in place; a miss fills a hole first, then evicts.
    always_comb begin
        if (hit)           tgt_way = hit_way;
        else if (free_any) tgt_way = free_way;
        else               tgt_way = lru_way;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NUM_SETS; s++) begin
                vld_q[s] <= '0;
                tag_q[s] <= '0;
                stp_q[s] <= '0;
            end
            stamp_q <= '0;
            rsp_q   <= '0;
        end else begin
            rsp_q.valid     <= lookup;
            rsp_q.hit       <= lookup && hit;
            rsp_q.miss      <= lookup && !hit;
            rsp_q.evict     <= lookup && !hit && !free_any;
            rsp_q.extra_hit <= lookup && (op == OP_MODIFY);
            if (lookup) begin
                stamp_q                   <= stamp_nxt;
                vld_q[set_idx][tgt_way]   <= 1'b1;
                tag_q[set_idx][tgt_way]   <= req_tag;
                stp_q[set_idx][tgt_way]   <= stamp_nxt;
            end
        end
    end

    assign rsp_valid     = rsp_q.valid;
    assign rsp_hit       = rsp_q.hit;
    assign rsp_miss      = rsp_q.miss;
    assign rsp_evict     = rsp_q.evict;
    assign rsp_extra_hit = rsp_q.extra_hit;

    logic [1:0] hit_inc, miss_inc, evict_inc;
    assign hit_inc   = hit_bump(lookup && hit, lookup && (op == OP_MODIFY));
    assign miss_inc  = {1'b0, lookup && !hit};
    assign evict_inc = {1'b0, lookup && !hit && !free_any};

    cd_tally #(.CNT_W(CNT_W)) u_hits   (.clk(clk), .rst(rst), .bump(hit_inc),   .count(hit_count));
    cd_tally #(.CNT_W(CNT_W)) u_misses (.clk(clk), .rst(rst), .bump(miss_inc),  .count(miss_count));
    cd_tally #(.CNT_W(CNT_W)) u_evicts (.clk(clk), .rst(rst), .bump(evict_inc), .count(evict_count));
endmodule

// File: rtl/cache_tag_dir_chk.sv
module cache_tag_dir_chk #(
    parameter int CNT_W   = 32,
    parameter int STAMP_W = 32
) (
    input logic               clk,
    input logic               rst,
    input logic               acc_valid,
    input logic               acc_ready,
    input logic [1:0]         acc_op,
    input logic               rsp_valid,
    input logic               rsp_hit,
    input logic               rsp_miss,
    input logic               rsp_evict,
    input logic               rsp_extra_hit,
    input logic [CNT_W-1:0]   hit_count,
    input logic [CNT_W-1:0]   miss_count,
    input logic [CNT_W-1:0]   evict_count,
    input logic [STAMP_W-1:0] stamp_q
);
    logic seen;
    always_ff @(posedge clk) begin
        if (rst) seen <= 1'b0;
        else     seen <= 1'b1;
    end

    a_r11_ready_high: assert property (@(posedge clk) disable iff (rst)
        acc_ready);

    a_r11_rsp_follows: assert property (@(posedge clk) disable iff (rst)
        acc_valid && acc_op != 2'b00 |=> rsp_valid);

    a_r8_fetch_silent: assert property (@(posedge clk) disable iff (rst)
        acc_valid && acc_op == 2'b00 |=> !rsp_valid && $stable(hit_count)
            && $stable(miss_count) && $stable(evict_count) && $stable(stamp_q));

    a_r2_hit_xor_miss: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_hit ^ rsp_miss));

    a_r4_evict_on_miss: assert property (@(posedge clk) disable iff (rst)
        rsp_evict |-> rsp_miss && rsp_valid);

    a_r7_bonus_in_rsp: assert property (@(posedge clk) disable iff (rst)
        rsp_extra_hit |-> rsp_valid);

    a_r5_clock_step: assert property (@(posedge clk) disable iff (rst)
        acc_valid && acc_op != 2'b00 |=> stamp_q == $past(stamp_q) + STAMP_W'(1));

    a_r10_hits_hold: assert property (@(posedge clk) disable iff (rst)
        seen && $past(hit_count) == {CNT_W{1'b1}} |-> hit_count == {CNT_W{1'b1}});

    a_r10_misses_rise: assert property (@(posedge clk) disable iff (rst)
        seen |-> miss_count >= $past(miss_count));

    a_r9_idle_after_reset: assert property (@(posedge clk)
        $past(rst) && seen == 1'b0 |-> !rsp_valid);
endmodule

bind cache_tag_dir cache_tag_dir_chk #(.CNT_W(CNT_W), .STAMP_W(STAMP_W)) u_chk (.*);

// File: tb/sim_cache_tag_dir.sv
module sim_cache_tag_dir;
    localparam int SB = 2, OB = 2, NW = 2, CW = 8;
    localparam int NS = 1 << SB;
    localparam longint CMAX = (1 << CW) - 1;

    logic clk = 1'b0, rst = 1'b1;
    logic acc_valid = 1'b0;
    logic [1:0] acc_op = 2'b00;
    logic [63:0] acc_addr = '0;
    logic acc_ready, rsp_valid, rsp_hit, rsp_miss, rsp_evict, rsp_extra_hit;
    logic [CW-1:0] hit_count, miss_count, evict_count;

    always #4 clk = ~clk;

    cache_tag_dir #(.SET_BITS(SB), .OFFSET_BITS(OB), .WAYS(NW), .CNT_W(CW), .STAMP_W(32)) u0 (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_ready(acc_ready),
        .acc_op(acc_op), .acc_addr(acc_addr), .rsp_valid(rsp_valid),
        .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_evict(rsp_evict),
        .rsp_extra_hit(rsp_extra_hit), .hit_count(hit_count),
        .miss_count(miss_count), .evict_count(evict_count));

    int n_run = 0, n_fail = 0;
    bit finished = 1'b0;

    // Reference state
    bit     mv [NS][NW];
    longint mt [NS][NW];
    longint ms [NS][NW];
    longint mclk = 0, e_hit = 0, e_miss = 0, e_evict = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint sat(input longint v);
        return (v > CMAX) ? CMAX : v;
    endfunction

    function automatic logic [63:0] mk(input longint tag, input int set, input int off);
        return (64'(tag) << (SB + OB)) | (64'(set) << OB) | 64'(off);
    endfunction

    task automatic do_access(input logic [1:0] op, input logic [63:0] addr);
        int set;
        longint tag;
        bit x_v, x_h, x_m, x_e, x_x;
        int way;
        string lbl;
        set = int'(addr[OB +: SB]);
        tag = longint'(addr >> (SB + OB));
        x_v = 0; x_h = 0; x_m = 0; x_e = 0; x_x = 0;
        lbl = "R8";
        if (op != 2'b00) begin
            x_v = 1; x_x = (op == 2'b11);
            mclk++;
            way = -1;
            for (int w = 0; w < NW; w++)
                if (way < 0 && mv[set][w] && mt[set][w] == tag) way = w;
            if (way >= 0) begin
                x_h = 1; lbl = "R2 R5";
            end else begin
                x_m = 1;
                for (int w = 0; w < NW; w++)
                    if (way < 0 && !mv[set][w]) way = w;
                if (way >= 0) lbl = "R3";
                else begin
                    x_e = 1; lbl = "R4 R5"; way = 0;
                    for (int w = 1; w < NW; w++)
                        if (ms[set][w] < ms[set][way]) way = w;
                end
            end
            mv[set][way] = 1; mt[set][way] = tag; ms[set][way] = mclk;
            e_hit   = sat(e_hit + x_h + x_x);
            e_miss  = sat(e_miss + x_m);
            e_evict = sat(e_evict + x_e);
            if (x_x) lbl = {lbl, " R7"};
            else if (op == 2'b10) lbl = {lbl, " R6"};
        end
        acc_valid = 1'b1; acc_op = op; acc_addr = addr;
        @(negedge clk);
        acc_valid = 1'b0;
        chk(rsp_valid == x_v, {lbl, " R11 rsp_valid"}, rsp_valid, x_v);
        chk(rsp_hit == x_h && rsp_miss == x_m, {lbl, " R1 hit/miss"},
            {rsp_hit, rsp_miss}, {x_h, x_m});
        chk(rsp_evict == x_e && rsp_extra_hit == x_x, {lbl, " evict/extra"},
            {rsp_evict, rsp_extra_hit}, {x_e, x_x});
        chk(hit_count == e_hit, {lbl, " R10 hit_count"}, hit_count, e_hit);
        chk(miss_count == e_miss, {lbl, " R10 miss_count"}, miss_count, e_miss);
        chk(evict_count == e_evict, {lbl, " R10 evict_count"}, evict_count, e_evict);
    endtask

    initial begin
        for (int s = 0; s < NS; s++)
            for (int w = 0; w < NW; w++) begin
                mv[s][w] = 0; mt[s][w] = 0; ms[s][w] = 0;
            end
        repeat (5) @(negedge clk);
        chk(rsp_valid == 0 && hit_count == 0 && miss_count == 0 && evict_count == 0,
            "R9 reset state", {rsp_valid, hit_count, miss_count, evict_count}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(acc_ready == 1'b1, "R11 ready high", acc_ready, 1);

        // R1: offset ignored, set index separates
        do_access(2'b01, mk(1, 0, 0));
        do_access(2'b01, mk(1, 0, 3));
        do_access(2'b01, mk(1, 1, 0));
        @(negedge clk);
        chk(rsp_valid == 0, "R11 single-cycle pulse", rsp_valid, 0);
        // R6: store behaves like load
        do_access(2'b10, mk(1, 0, 1));
        do_access(2'b10, mk(2, 0, 0));
        // R4 R5: set 0 full; tag1 older than tag2 -> evict tag1
        do_access(2'b01, mk(3, 0, 0));
        do_access(2'b01, mk(2, 0, 2));
        // R5: refresh tag3 then bring tag4 -> tag2 goes
        do_access(2'b01, mk(3, 0, 0));
        do_access(2'b01, mk(4, 0, 0));
        do_access(2'b01, mk(3, 0, 0));
        // R7: modify hit and modify miss with eviction
        do_access(2'b11, mk(4, 0, 1));
        do_access(2'b11, mk(5, 0, 0));
        // R8: fetches change nothing; next lookup would reveal a fill
        do_access(2'b00, mk(6, 2, 0));
        do_access(2'b00, mk(6, 2, 0));
        do_access(2'b01, mk(7, 2, 0));
        do_access(2'b01, mk(6, 2, 0));
        // R1: top tag bit participates
        do_access(2'b01, 64'h8000_0000_0000_0004);
        do_access(2'b01, 64'h0000_0000_0000_0004);
        do_access(2'b01, 64'h8000_0000_0000_0007);

        // Mixed sweep; drives counters into saturation (R10)
        for (int i = 0; i < 700; i++) begin
            int k;
            logic [1:0] op;
            k = (i * 7 + 3) % 5;
            op = (k == 4) ? 2'b01 : 2'(k);
            do_access(op, mk((i * 3 + i / 5) % 5, (i / 2) % NS, i % 4));
        end
        chk(hit_count == CMAX && miss_count == CMAX, "R10 saturated",
            {hit_count, miss_count}, {CMAX[7:0], CMAX[7:0]});

        rst = 1'b1;
        @(negedge clk);
        chk(hit_count == 0 && evict_count == 0 && rsp_valid == 0, "R9 re-reset",
            {hit_count, evict_count}, 0);
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule